// File: doc/BRIEF.md
# SPI EEPROM Word Reader

This block fetches single 16-bit words from a small serial EEPROM attached over a four-wire SPI bus. Software drives one 32-bit command register: it writes a word address with the start bit set, and the engine runs the serial transaction on its own. When the word has arrived, the engine places it in the upper half of the same register and raises a done flag. Software polls that flag and then reads the data.

Before each read the engine asks the device whether it is still busy. It repeats that query until the device reports ready, and only then sends the read instruction. A second command, given on a separate pulse input, walks the whole 64-word image in order and adds the words. It then reports whether the 16-bit sum matches the fixed image signature 0xBABA. The command register is left untouched by that walk.

Top module: `eeword_fetch`

## Requirements
- R1: After reset the command register reads 0, chip select is high, the serial clock is low and the image-checked flag is 0. Register layout: bit 0 is start/busy, bit 1 is done, bits 15:2 are the word address and bits 31:16 are the returned data.
- R2: A register write with bit 0 set, made while the engine is idle, stores bits 15:2 and clears done. From the next cycle bit 0 reads 1. Bit 0 clears and done sets in the same cycle, and only after both data bytes have been received. Bits 0 and 1 never read 1 together.
- R3: A word read keeps chip select low across the transaction. It sends opcode 0x03 and then the byte address, which is twice the word address modulo 64 (one byte, most significant bit first). It then receives two bytes: the first becomes data bits 23:16 and the second becomes bits 31:24.
- R4: The bus uses SPI mode 0. The serial clock idles low while chip select is high. Within a byte the clock period is DIV system clocks. The output data line changes only while the serial clock is low.
- R5: Each transfer is preceded by a ready query: chip select goes low, opcode 0x05 is sent and one status byte is received. If status bit 0 is 1, chip select goes high and the query is repeated. The read instruction is sent only after a query that returns bit 0 = 0.
- R6: A register write with bit 0 set while a word read or an image check is in progress is ignored. The address field keeps its value and the running read returns its own word.
- R7: A register write with bit 0 clear has no effect on the register.
- R8: A pulse on chk_go while idle clears img_checked on the next cycle. The engine then reads words 0 to 63 in ascending order, each as in R3 and R5. At the end it sets img_checked, and img_ok reads 1 exactly when the 16-bit sum of the words modulo 65536 equals 0xBABA.
- R9: An image check leaves the command register unchanged.
- R10: If a start write and chk_go arrive in the same idle cycle, the word read is accepted and chk_go is ignored: img_checked and img_ok keep their values.
- R11: A chk_go pulse while a word read is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_wr_en | input | 1 | Command register write strobe |
| reg_wr_data | input | 32 | Command register write value |
| reg_rd_data | output | 32 | Command register contents |
| chk_go | input | 1 | Pulse starting an image check |
| img_checked | output | 1 | An image check has completed since the last chk_go |
| img_ok | output | 1 | The last image check matched the signature |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The two requests that can collide are a start write to the command register and a chk_go pulse. The bench drives both in the same idle cycle and confirms three things: exactly one read transaction appears on the bus, the returned word belongs to the written address, and the image flags keep their earlier values. It also drives chk_go in the middle of a word read, and a start write during a running read. In each case it counts read opcodes on the bus and compares the register fields against its EEPROM model on every clock.

// File: rtl/eew_pkg.sv
package eew_pkg;

    localparam logic [7:0]  OP_READ = 8'h03;
    localparam logic [7:0]  OP_RDSR = 8'h05;
    localparam logic [15:0] IMG_SIG = 16'hBABA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_OP,
        ST_POLL_ST,
        ST_GAP,
        ST_RD_OP,
        ST_ADDR,
        ST_LO,
        ST_HI
    } eew_state_e;

    // Packed order equals the register bit layout (data 31:16 ... start 0)
    typedef struct packed {
        logic [15:0] data;
        logic [13:0] addr;
        logic        done;
        logic        start;
    } eew_cmd_t;

endpackage

// File: rtl/eew_spi_shift.sv
module eew_spi_shift #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       fin
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
        $error("DIV must be even and at least 2");
    end

    typedef struct packed {
        logic          active;
        logic          sck;
        logic [CW-1:0] cnt;
        logic [2:0]    bits;
        logic [7:0]    txsh;
        logic [7:0]    rxsh;
        logic          fin;
    } shift_t;

    shift_t q, d;

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (go) begin
            d.active = 1'b1;
            d.sck    = 1'b0;
            d.cnt    = '0;
            d.bits   = '0;
            d.txsh   = tx;
        end else if (q.active) begin
            if (q.cnt == CW'(HALF - 1)) begin
                d.cnt = '0;
                if (!q.sck) begin
                    d.sck  = 1'b1;
                    d.rxsh = {q.rxsh[6:0], miso};
                end else begin
                    d.sck = 1'b0;
                    if (q.bits == 3'd7) begin
                        d.active = 1'b0;
                        d.fin    = 1'b1;
                    end else begin
                        d.bits = q.bits + 3'd1;
                        d.txsh = {q.txsh[6:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck  = q.sck;
    assign mosi = q.txsh[7];
    assign rx   = q.rxsh;
    assign fin  = q.fin;

endmodule

// File: rtl/eew_sum.sv
module eew_sum
    import eew_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        add,
    input  logic        last,
    input  logic [15:0] word,
    output logic        checked,
    output logic        ok
);
    typedef struct packed {
        logic [15:0] acc;
        logic        checked;
        logic        ok;
    } sum_t;

    sum_t q, d;
    logic [15:0] acc_next;

    always_comb begin
        d        = q;
        acc_next = q.acc + word;
        if (clr) begin
            d.acc     = '0;
            d.checked = 1'b0;
            d.ok      = 1'b0;
        end else if (add) begin
            d.acc = acc_next;
            if (last) begin
                d.checked = 1'b1;
                d.ok      = (acc_next == IMG_SIG);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign checked = q.checked;
    assign ok      = q.ok;

endmodule

// File: rtl/eeword_fetch.sv
module eeword_fetch
    import eew_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int WORDS      = 64,
    parameter bit POLL_READY = 1'b1,
    parameter int CS_GAP     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        chk_go,
    output logic        img_checked,
    output logic        img_ok,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int AW     = $clog2(WORDS);
    localparam int ABYTES = (AW + 1 + 7) / 8;
    localparam int ABW    = ABYTES * 8;
    localparam int IW     = (ABYTES > 1) ? $clog2(ABYTES) : 1;
    localparam int GW     = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

    // A parameter picks whether each transfer opens with a ready query
    localparam eew_state_e FIRST_ST = POLL_READY ? ST_POLL_OP : ST_RD_OP;
    localparam logic [7:0] FIRST_OP = POLL_READY ? OP_RDSR : OP_READ;

    typedef struct packed {
        eew_state_e     st;
        eew_cmd_t       cmd;
        logic           sum_mode;
        logic [AW-1:0]  widx;
        logic           cs_n;
        logic           go;
        logic [7:0]     tx;
        logic [7:0]     lo;
        logic [GW-1:0]  gap;
        logic           repoll;
        logic [IW-1:0]  abyte;
    } eng_t;

    eng_t q, d;

    logic       busy;
    logic       byte_fin;
    logic [7:0] byte_rx;
    logic       sum_clr, sum_add, sum_last;
    logic [15:0] word_in;
    logic       start_req;

    wire unused_wr_hi = ^reg_wr_data[31:16];

    function automatic logic [7:0] addr_byte(logic [AW-1:0] w, logic [IW-1:0] k);
        logic [ABW-1:0] b;
        b = ABW'({w, 1'b0});
        return b[(ABYTES - 1 - int'(k)) * 8 +: 8];
    endfunction

    assign busy      = (q.st != ST_IDLE);
    assign start_req = reg_wr_en && reg_wr_data[0];
    assign word_in   = {byte_rx, q.lo};

    always_comb begin
        d        = q;
        d.go     = 1'b0;
        sum_clr  = 1'b0;
        sum_add  = 1'b0;
        sum_last = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_req) begin
                    d.cmd.addr  = reg_wr_data[15:2];
                    d.cmd.done  = 1'b0;
                    d.cmd.start = 1'b1;
                    d.sum_mode  = 1'b0;
                    d.widx      = reg_wr_data[AW+1:2];
                    d.cs_n      = 1'b0;
                    d.go        = 1'b1;
                    d.tx        = FIRST_OP;
                    d.st        = FIRST_ST;
                end else if (chk_go) begin
                    sum_clr    = 1'b1;
                    d.sum_mode = 1'b1;
                    d.widx     = '0;
                    d.cs_n     = 1'b0;
                    d.go       = 1'b1;
                    d.tx       = FIRST_OP;
                    d.st       = FIRST_ST;
                end
            end
            ST_POLL_OP: begin
                if (byte_fin) begin
                    d.go = 1'b1;
                    d.tx = 8'h00;
                    d.st = ST_POLL_ST;
                end
            end
            ST_POLL_ST: begin
                if (byte_fin) begin
                    d.cs_n   = 1'b1;
                    d.gap    = '0;
                    d.repoll = byte_rx[0];
                    d.st     = ST_GAP;
                end
            end
            ST_GAP: begin
                if (q.gap == GW'(CS_GAP - 1)) begin
                    d.cs_n = 1'b0;
                    d.go   = 1'b1;
                    if (q.repoll) begin
                        d.tx = OP_RDSR;
                        d.st = ST_POLL_OP;
                    end else begin
                        d.tx = OP_READ;
                        d.st = ST_RD_OP;
                    end
                end else begin
                    d.gap = q.gap + GW'(1);
                end
            end
            ST_RD_OP: begin
                if (byte_fin) begin
                    d.go    = 1'b1;
                    d.abyte = '0;
                    d.tx    = addr_byte(q.widx, '0);
                    d.st    = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (byte_fin) begin
                    d.go = 1'b1;
                    if (q.abyte == IW'(ABYTES - 1)) begin
                        d.tx = 8'h00;
                        d.st = ST_LO;
                    end else begin
                        d.abyte = q.abyte + IW'(1);
                        d.tx    = addr_byte(q.widx, q.abyte + IW'(1));
                    end
                end
            end
            ST_LO: begin
                if (byte_fin) begin
                    d.lo = byte_rx;
                    d.go = 1'b1;
                    d.tx = 8'h00;
                    d.st = ST_HI;
                end
            end
            ST_HI: begin
                if (byte_fin) begin
                    d.cs_n = 1'b1;
                    if (!q.sum_mode) begin
                        d.cmd.data  = word_in;
                        d.cmd.done  = 1'b1;
                        d.cmd.start = 1'b0;
                        d.st        = ST_IDLE;
                    end else begin
                        sum_add = 1'b1;
                        if (q.widx == AW'(WORDS - 1)) begin
                            sum_last = 1'b1;
                            d.st     = ST_IDLE;
                        end else begin
                            d.widx   = q.widx + AW'(1);
                            d.gap    = '0;
                            d.repoll = POLL_READY;
                            d.st     = ST_GAP;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    eew_spi_shift #(.DIV(DIV)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (q.go),
        .tx   (q.tx),
        .miso (spi_miso),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .rx   (byte_rx),
        .fin  (byte_fin)
    );

    eew_sum u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sum_clr),
        .add    (sum_add),
        .last   (sum_last),
        .word   (word_in),
        .checked(img_checked),
        .ok     (img_ok)
    );

    assign reg_rd_data = q.cmd;
    assign spi_cs_n    = q.cs_n;

endmodule

// File: rtl/eew_checker.sv
module eew_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [15:0] reg_wr_lo,
    input logic [31:0] reg_rd_data,
    input logic        chk_go,
    input logic        img_checked,
    input logic        spi_sck,
    input logic        spi_cs_n,
    input logic        spi_mosi,
    input logic        engine_busy
);
    logic start_req;
    assign start_req = reg_wr_en && reg_wr_lo[0];

    assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !engine_busy) |=>
            (reg_rd_data[0] && !reg_rd_data[1] && reg_rd_data[15:2] == $past(reg_wr_lo[15:2])));

    assert_start_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[1] |-> !reg_rd_data[0]);

    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && reg_wr_en) |=> $stable(reg_rd_data[15:2]));

    assert_plain_write_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_lo[0] && !engine_busy) |=> $stable(reg_rd_data));

    assert_check_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_go && !start_req && !engine_busy) |=> !img_checked);

    assert_dual_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_go && start_req && !engine_busy) |=> $stable(img_checked));

endmodule

bind eeword_fetch eew_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_lo  (reg_wr_data[15:0]),
    .reg_rd_data(reg_rd_data),
    .chk_go     (chk_go),
    .img_checked(img_checked),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .spi_mosi   (spi_mosi),
    .engine_busy(busy)
);

// File: tb/tb_eeword_fetch.sv
`timescale 1ns/1ps
module tb_eeword_fetch;
    localparam int DIV   = 4;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        chk_go = 1'b0;
    logic [31:0] reg_rd_data;
    logic        img_checked, img_ok;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        miso_r = 1'b0;

    always #4 clk = ~clk;

    eeword_fetch #(.DIV(DIV), .WORDS(WORDS), .POLL_READY(1'b1), .CS_GAP(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .chk_go(chk_go), .img_checked(img_checked),
        .img_ok(img_ok), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(miso_r)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- EEPROM model ----------------
    logic [15:0] mem [WORDS];
    int          bc = 0;
    logic [7:0]  op = 8'h00;
    logic [15:0] shin = '0;
    int          busy_left = 0;
    logic        stat_bit = 1'b0;
    int          polls_seen = 0;
    int          reads_seen = 0;
    bit          ready_ok = 1'b0;
    logic [7:0]  addr_log [$];
    realtime     last_rise = 0;

    always @(negedge spi_cs_n) begin
        bc = 0;
        op = 8'h00;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            shin = {shin[14:0], spi_mosi};
            bc++;
            if ((bc % 8) != 1)
                check(($realtime - last_rise) == DIV * 8.0, "R4 sck period in byte",
                      32'($rtoi($realtime - last_rise)), 32'(DIV * 8));
            last_rise = $realtime;
            if (bc == 8) begin
                op = shin[7:0];
                if (op == 8'h05) begin
                    polls_seen++;
                    stat_bit = (busy_left > 0);
                end else if (op == 8'h03) begin
                    reads_seen++;
                    check(ready_ok, "R5 read sent after ready status", 32'(ready_ok), 32'd1);
                    ready_ok = 1'b0;
                end else begin
                    check(1'b0, "R3 R5 opcode", 32'(op), 32'h03);
                end
            end
            if (bc == 16 && op == 8'h03) addr_log.push_back(shin[7:0]);
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (op == 8'h05)
                miso_r = (bc == 15) ? stat_bit : 1'b0;
            else if (op == 8'h03 && bc >= 16 && bc < 32) begin
                logic [15:0] w, s;
                w = mem[addr_log[$] >> 1];
                s = {w[7:0], w[15:8]};
                miso_r = s[15 - (bc - 16)];
            end else
                miso_r = 1'b0;
        end
    end

    always @(posedge spi_cs_n) begin
        if (op == 8'h05) begin
            if (stat_bit) busy_left--;
            else          ready_ok = 1'b1;
        end
        op = 8'h00;
    end

    // ---------------- per-clock comparison ----------------
    bit          exp_valid = 1'b0;
    logic [15:0] exp_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            check(!(reg_rd_data[0] && reg_rd_data[1]), "R2 start and done exclusive", reg_rd_data, 32'h0);
            check(!(spi_cs_n && spi_sck), "R4 sck low when deselected", {30'd0, spi_cs_n, spi_sck}, 32'd2);
            if (reg_rd_data[1] && exp_valid)
                check(reg_rd_data[31:16] == exp_data, "R3 returned word", 32'(reg_rd_data[31:16]), 32'(exp_data));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 20000 && !reg_rd_data[1]; i++) @(negedge clk);
        check(reg_rd_data[1], req, reg_rd_data, 32'h2);
    endtask

    task automatic wait_checked(input string req);
        for (int i = 0; i < 60000 && !img_checked; i++) @(negedge clk);
        check(img_checked, req, 32'(img_checked), 32'd1);
    endtask

    task automatic do_read(input int a, input int busy);
        int p0, r0;
        busy_left = busy;
        p0 = polls_seen;
        r0 = reads_seen;
        exp_valid = 1'b0;
        wr({16'h0, 14'(a), 2'b01});
        check(reg_rd_data[0] && !reg_rd_data[1], "R2 start set, done cleared", reg_rd_data, 32'h1);
        exp_data  = mem[a % WORDS];
        exp_valid = 1'b1;
        wait_done("R2 done after read");
        check(reg_rd_data == {mem[a % WORDS], 14'(a), 2'b10}, "R2 R3 register after read",
              reg_rd_data, {mem[a % WORDS], 14'(a), 2'b10});
        check(addr_log[$] == 8'(2 * (a % WORDS)), "R3 byte address", 32'(addr_log[$]), 32'(2 * (a % WORDS)));
        check(polls_seen - p0 == busy + 1, "R5 ready queries", 32'(polls_seen - p0), 32'(busy + 1));
        check(reads_seen - r0 == 1, "R3 one read instruction", 32'(reads_seen - r0), 32'd1);
    endtask

    task automatic run_check(input bit want_ok);
        logic [31:0] save;
        save = reg_rd_data;
        addr_log.delete();
        @(negedge clk);
        chk_go = 1'b1;
        @(negedge clk);
        chk_go = 1'b0;
        check(!img_checked, "R8 flag cleared on command", 32'(img_checked), 32'd0);
        wait_checked("R8 check completes");
        check(img_ok == want_ok, "R8 signature result", 32'(img_ok), 32'(want_ok));
        check(addr_log.size() == WORDS, "R8 word count", 32'(addr_log.size()), 32'(WORDS));
        for (int i = 0; i < WORDS && i < addr_log.size(); i++)
            if (addr_log[i] != 8'(2 * i)) check(1'b0, "R8 ascending order", 32'(addr_log[i]), 32'(2 * i));
        check(reg_rd_data == save, "R9 register untouched by check", reg_rd_data, save);
    endtask

    bit finished = 1'b0;

    initial begin
        logic [15:0] acc;
        logic [31:0] save;
        int r0;
        acc = '0;
        for (int i = 0; i < WORDS - 1; i++) begin
            mem[i] = 16'(i * 16'h1357 + 16'h2468);
            acc    = acc + mem[i];
        end
        mem[WORDS - 1] = 16'hBABA - acc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rd_data == 32'h0, "R1 register reset", reg_rd_data, 32'h0);
        check(spi_cs_n && !spi_sck, "R1 bus idle", {30'd0, spi_cs_n, spi_sck}, 32'd2);
        check(!img_checked, "R1 image flag reset", 32'(img_checked), 32'd0);

        do_read(5, 0);
        do_read(63, 2);
        do_read(0, 1);
        do_read(70, 0);

        save = reg_rd_data;
        wr(32'h0000_0AA8);
        repeat (3) @(negedge clk);
        check(reg_rd_data == save, "R7 write without start", reg_rd_data, save);

        // R6: start while busy
        r0 = reads_seen;
        exp_valid = 1'b0;
        wr({16'h0, 14'd10, 2'b01});
        exp_data = mem[10];
        exp_valid = 1'b1;
        repeat (40) @(negedge clk);
        wr({16'h0, 14'd20, 2'b01});
        check(reg_rd_data[15:2] == 14'd10, "R6 address kept", 32'(reg_rd_data[15:2]), 32'd10);
        wait_done("R6 running read completes");
        check(reg_rd_data[31:16] == mem[10], "R6 own word returned", 32'(reg_rd_data[31:16]), 32'(mem[10]));
        repeat (2000) @(negedge clk);
        check(reads_seen - r0 == 1, "R6 no second read", 32'(reads_seen - r0), 32'd1);

        run_check(1'b1);
        mem[17] = mem[17] ^ 16'h0100;
        run_check(1'b0);
        mem[17] = mem[17] ^ 16'h0100;

        // R10: start and chk_go in the same idle cycle
        r0 = reads_seen;
        exp_valid = 1'b0;
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_data = {16'h0, 14'd7, 2'b01};
        chk_go = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = '0;
        chk_go = 1'b0;
        exp_data = mem[7];
        exp_valid = 1'b1;
        check(img_checked == 1'b1, "R10 image flag kept", 32'(img_checked), 32'd1);
        check(reg_rd_data[0], "R10 word read accepted", reg_rd_data, 32'h1d);
        wait_done("R10 read completes");
        repeat (3000) @(negedge clk);
        check(reads_seen - r0 == 1, "R10 only one transaction", 32'(reads_seen - r0), 32'd1);
        check(img_checked && !img_ok, "R10 image status unchanged", {30'd0, img_checked, img_ok}, 32'd2);

        // R11: chk_go during a word read
        r0 = reads_seen;
        exp_valid = 1'b0;
        wr({16'h0, 14'd3, 2'b01});
        exp_data = mem[3];
        exp_valid = 1'b1;
        repeat (20) @(negedge clk);
        chk_go = 1'b1;
        @(negedge clk);
        chk_go = 1'b0;
        wait_done("R11 read completes");
        repeat (3000) @(negedge clk);
        check(reads_seen - r0 == 1, "R11 check pulse ignored", 32'(reads_seen - r0), 32'd1);
        check(img_checked == 1'b1, "R11 image flag kept", 32'(img_checked), 32'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule